// File: doc/BRIEF.md
# Up-Down Counter with Hold on Conflicting Direction

This block is a small synchronous binary counter that steps in either direction under two independent direction strobes, one for counting upward and one for counting downward. If exactly one strobe is high at a rising clock edge, the count moves by one in that direction. It wraps around at both ends of its range. If both strobes are high, or both are low, the count stays where it is. A conflicting request therefore freezes the counter rather than letting one direction win.

Two combinational flags support cascading. The carry flag rises in the cycle where an upward step from the all-ones value is pending. The borrow flag rises in the cycle where a downward step from zero is pending. A wider counter can use either flag as the step enable of a following stage. An active-low reset clears the count at once, without waiting for a clock edge. The release of that reset passes through a short synchronizer, so counting starts a fixed number of edges after the reset input goes high.

Top module: `updown_hold_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `carry_out` and `borrow_out` are 0, with no clock edge needed after `rst_n` falls.
- R2: After `rst_n` rises, `count` stays 0 on the first SYNC_STAGES (default 2) rising edges whatever the strobes do. The first step can occur on edge SYNC_STAGES+1.
- R3: With `cnt_up`=1 and `cnt_dn`=0 at a rising edge, `count` becomes its previous value plus one.
- R4: With `cnt_up`=0 and `cnt_dn`=1 at a rising edge, `count` becomes its previous value minus one.
- R5: With `cnt_up`=1 and `cnt_dn`=1 at a rising edge, `count` keeps its value.
- R6: With `cnt_up`=0 and `cnt_dn`=0 at a rising edge, `count` keeps its value.
- R7: Steps are modulo 2^WIDTH: an upward step from all ones (15 at the default width) gives 0, and a downward step from 0 gives all ones.
- R8: `carry_out` is 1 exactly when counting is running, `cnt_up`=1, `cnt_dn`=0 and `count` is all ones. It is valid in the same cycle as those inputs.
- R9: `borrow_out` is 1 exactly when counting is running, `cnt_dn`=1, `cnt_up`=0 and `count` is 0. It is valid in the same cycle as those inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| cnt_up | input | 1 | Upward step strobe |
| cnt_dn | input | 1 | Downward step strobe |
| count | output | WIDTH | Current count value |
| carry_out | output | 1 | Upward wrap pending this cycle |
| borrow_out | output | 1 | Downward wrap pending this cycle |

## Verification
A new count is due one rising edge after the strobes that request it. The carry and borrow flags are due in the same cycle as the strobes and count that produce them, and the reset clear is due at once, with no edge needed. The one extra delay is the reset release: the count stays at zero for SYNC_STAGES edges. The bench drives strobes on the falling edge and compares all three outputs against its own model shortly after that edge. This moment is after the model has taken in the previous rising edge and before the next rising edge. For the mid-run reset, the count is sampled a fraction of a cycle after `rst_n` falls, away from any clock edge.

// File: rtl/udc_pkg.sv
package udc_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_INC  = 2'b01,
    DIR_DEC  = 2'b10
  } dir_e;
endpackage

// File: rtl/udc_rst_sync.sv
module udc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic run
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign run = chain_q[STAGES-1];

  // R1: reset drives the run qualifier low
  a_r1_run_low: assert property (@(posedge clk) !rst_n |-> !run);
endmodule

// File: rtl/udc_dir_decode.sv
module udc_dir_decode
  import udc_pkg::*;
(
  input  logic run,
  input  logic up_req,
  input  logic dn_req,
  output dir_e dir
);
  always_comb begin
    dir = DIR_HOLD;
    if (run) begin
      unique case ({dn_req, up_req})
        2'b01:   dir = DIR_INC;
        2'b10:   dir = DIR_DEC;
        default: dir = DIR_HOLD;
      endcase
    end
  end

  // R5: conflicting strobes never yield a step
  always_comb begin
    a_r5_conflict_holds: assert (!(up_req && dn_req) || dir == DIR_HOLD);
  end
endmodule

// File: rtl/udc_terminal.sv
module udc_terminal
  import udc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  dir_e             dir,
  input  logic [WIDTH-1:0] cur,
  output logic             carry,
  output logic             borrow
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] BOT = '0;

  always_comb begin
    carry  = (dir == DIR_INC) && (cur == TOP);
    borrow = (dir == DIR_DEC) && (cur == BOT);
  end
endmodule

// File: rtl/updown_hold_counter.sv
module updown_hold_counter
  import udc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  output logic [WIDTH-1:0] count,
  output logic             carry_out,
  output logic             borrow_out
);
  localparam logic [WIDTH-1:0] STEP = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] ALL1 = {WIDTH{1'b1}};

  logic             run;
  dir_e             dir;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  udc_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run)
  );

  udc_dir_decode u_dec (
    .run    (run),
    .up_req (cnt_up),
    .dn_req (cnt_dn),
    .dir    (dir)
  );

  udc_terminal #(.WIDTH(WIDTH)) u_term (
    .dir    (dir),
    .cur    (cnt_q),
    .carry  (carry_out),
    .borrow (borrow_out)
  );

  always_comb begin
    cnt_en = (dir != DIR_HOLD);
    cnt_d  = cnt_q;
    if (dir == DIR_INC)      cnt_d = cnt_q + STEP;
    else if (dir == DIR_DEC) cnt_d = cnt_q - STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  a_r2_frozen_until_run: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count == '0);
  a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_up && !cnt_dn) |=> count == $past(count) + STEP);
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt_dn && !cnt_up) |=> count == $past(count) - STEP);
  a_r5_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up && cnt_dn) |=> $stable(count));
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_up && !cnt_dn) |=> $stable(count));
  a_r7_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |=> count == '0);
  a_r7_wrap_down: assert property (@(posedge clk) disable iff (!rst_n)
    borrow_out |=> count == ALL1);
  a_r8_carry_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (count == ALL1 && cnt_up && !cnt_dn));
  a_r9_borrow_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    borrow_out |-> (count == '0 && cnt_dn && !cnt_up));
  a_r8_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(carry_out && borrow_out));
endmodule

// File: tb/sim_updown_hold_counter.sv
module sim_updown_hold_counter;
  localparam int W  = 4;
  localparam int SS = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         up = 1'b0;
  logic         dn = 1'b0;
  logic [W-1:0] count;
  logic         carry, borrow;

  int     n_cmp = 0;
  int     n_bad = 0;
  bit     done  = 0;
  int     exp_cnt = 0;
  int     since = 0;
  string  cnt_tag = "R1";

  always #4 clk = ~clk;

  updown_hold_counter #(.WIDTH(W), .SYNC_STAGES(SS)) u0 (
    .clk(clk), .rst_n(rst_n), .cnt_up(up), .cnt_dn(dn),
    .count(count), .carry_out(carry), .borrow_out(borrow)
  );

  // behavioural reference: integer count modulo 16
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_cnt <= 0;
      since   <= 0;
    end else begin
      if (since >= SS) begin
        if (up && !dn)      exp_cnt <= (exp_cnt + 1) % 16;
        else if (dn && !up) exp_cnt <= (exp_cnt + 15) % 16;
      end
      if (since < 100) since <= since + 1;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit run = rst_n && (since >= SS);
    int ec  = (run && up && !dn && exp_cnt == 15) ? 1 : 0;
    int eb  = (run && dn && !up && exp_cnt == 0) ? 1 : 0;
    check(rst_n ? cnt_tag : "R1", "count", int'(count), exp_cnt);
    check(rst_n ? "R8" : "R1", "carry", int'(carry), ec);
    check(rst_n ? "R9" : "R1", "borrow", int'(borrow), eb);
  endtask

  task automatic step(input bit u, input bit d);
    @(negedge clk);
    up = u; dn = d;
    #2;
    compare_all();
    if (!rst_n || since < SS)   cnt_tag = "R2";
    else if (u && !d)           cnt_tag = (exp_cnt == 15) ? "R7" : "R3";
    else if (d && !u)           cnt_tag = (exp_cnt == 0)  ? "R7" : "R4";
    else if (u && d)            cnt_tag = "R5";
    else                        cnt_tag = "R6";
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    cnt_tag = "R2";
  endtask

  initial begin
    // R1: reset state with strobes active
    up = 1'b1;
    repeat (3) step(1'b1, 1'b0);
    release_reset();
    // R2: strobes ignored while synchronizer fills
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    // R3, R7, R8: run past the top
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0);
    // R5: both high
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    // R6: idle
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0);
    // R4, R7, R9: run past zero
    for (int i = 0; i < 24; i++) step(1'b0, 1'b1);
    // R5/R8: conflict at all ones must not carry
    while (exp_cnt != 15) step(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    // R5/R9: conflict at zero must not borrow
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    // mixed pattern
    for (int i = 0; i < 40; i++) step(((i * 7) % 3) == 0, ((i * 5) % 4) == 1);
    // R1: asynchronous clear mid-cycle
    while (exp_cnt == 0) step(1'b1, 1'b0);
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check("R1", "async count", int'(count), 0);
    check("R1", "async carry", int'(carry), 0);
    check("R1", "async borrow", int'(borrow), 0);
    step(1'b0, 1'b1);
    release_reset();
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule